// File: doc/BRIEF.md
# Peripheral Request to Channel Mapper

This block sits between a large set of peripheral DMA request lines and a smaller set of DMA channels. A table of programmable map entries, one per request line, names the channel that line serves and says whether the mapping is live. Each clock, the block samples the request lines and forms one request level per channel from every live entry that points at that channel. It then compares that level with the value it had one clock earlier.

When a channel's level rises, the block pulses a set strobe for that channel's request-after-start flag, plus a wake strobe so the channel engine can try a transfer and re-evaluate its interrupts. When the level falls, it pulses a set strobe for the end-of-receive flag and a clear strobe for the request-after-start flag. The status register, arbitration and data movement live elsewhere and consume these strobes.

Software reaches the map table through a simple word-addressed read/write port. Entries 0 to 63 sit at consecutive words of a low window. Entries 64 upward sit in a separate high window, but their index continues from 63. A write that marks an entry live while naming a channel the build does not have is refused and reported with a one-cycle error strobe.

Top module: `reqmap_top`

## Requirements
- R1: After reset every map entry is zero (not live, channel 0), all per-channel outputs are zero, `cfg_err_o` is low and `cfg_rdata_o` is zero.
- R2: A map entry stores bit 7 of the written data (live) and bits 4..0 (channel). A read strobe returns the addressed entry on `cfg_rdata_o` in the cycle after the strobe, with bit 7 = live, bits 4..0 = channel and bits 6..5 always zero.
- R3: Entry i for i < 64 is at word address `LO_BASE + i`. Entry i for i >= 64 is at word address `HI_BASE + (i - 64)`. A read of any other address returns zero, and a write to it changes no entry and raises no error.
- R4: A write with bit 7 set and a channel number of `NUM_CH` or more leaves the entry unchanged and pulses `cfg_err_o` for one cycle after the write. A write with bit 7 clear is stored whatever its channel field holds.
- R5: A request line whose entry is not live has no effect on any channel output.
- R6: When a channel's level goes from 0 to 1, `ras_set_o` and `wake_o` for that channel are high for exactly one cycle. This pulse appears two clock edges after the request input changes.
- R7: When a channel's level goes from 1 to 0, `eor_set_o` and `ras_clr_o` for that channel are high for exactly one cycle, with the same two-edge latency.
- R8: Several request lines may map to one channel. The channel level is their OR, so a second line rising while the level is already high gives no pulse, and the fall pulse comes only when the last line drops.
- R9: `chan_req_o` shows each channel's sampled level two clock edges after the request inputs change.
- R10: For one channel, a rise pulse and a fall pulse never occur in the same cycle. Edges on different channels in the same cycle give pulses on each of those channels together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_REQ | Peripheral request lines, active high |
| cfg_wr_i | input | 1 | Map table write strobe |
| cfg_rd_i | input | 1 | Map table read strobe |
| cfg_addr_i | input | ADDR_W | Word address for read or write |
| cfg_wdata_i | input | 8 | Write data (bit 7 live, bits 4..0 channel) |
| cfg_rdata_o | output | 8 | Read data, valid the cycle after a read strobe |
| cfg_err_o | output | 1 | One-cycle strobe for a refused write |
| chan_req_o | output | NUM_CH | Registered per-channel request level |
| ras_set_o | output | NUM_CH | Set strobe for the request-after-start flag |
| ras_clr_o | output | NUM_CH | Clear strobe for the request-after-start flag |
| eor_set_o | output | NUM_CH | Set strobe for the end-of-receive flag |
| wake_o | output | NUM_CH | Strobe that prompts the channel engine to run |

## Verification
A corrupted map entry shows up in one of two ways. It reads back wrong in the cycle after a read strobe, or a request line drives the wrong channel's `chan_req_o` and strobes two edges after it toggles. The bench therefore walks every entry and every request line, so each table slot and each routing path is exercised once. A broken previous-level register shows up on the very next edge as a missing pulse, a repeated pulse, or a rise and fall in the wrong cycle. Refused writes are caught one cycle later, both by the error strobe and by reading the entry back.

// File: rtl/reqmap_pkg.sv
package reqmap_pkg;

    localparam int LIVE_BIT  = 7;
    localparam int CHF_W     = 5;
    localparam int LO_SPAN   = 64;

    typedef struct packed {
        logic             live;
        logic [CHF_W-1:0] ch;
    } map_ent_t;

    function automatic map_ent_t ent_from_bus(input logic [7:0] d);
        map_ent_t e;
        e.live = d[LIVE_BIT];
        e.ch   = d[CHF_W-1:0];
        return e;
    endfunction

    function automatic logic [7:0] ent_to_bus(input map_ent_t e);
        return {e.live, 2'b00, e.ch};
    endfunction

endpackage

// File: rtl/reqmap_table.sv
module reqmap_table
    import reqmap_pkg::*;
#(
    parameter int          NUM_REQ = 75,
    parameter int          NUM_CH  = 16,
    parameter int          ADDR_W  = 12,
    parameter int unsigned LO_BASE = 32'h040,
    parameter int unsigned HI_BASE = 32'h440
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic                  rd_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [7:0]            wdata_i,
    output logic [7:0]            rdata_o,
    output logic                  err_o,
    output map_ent_t [NUM_REQ-1:0] map_o
);

    localparam int          IDX_W  = $clog2(NUM_REQ);
    localparam int unsigned LO_CNT = (NUM_REQ < LO_SPAN) ? NUM_REQ : LO_SPAN;
    localparam int unsigned HI_CNT = NUM_REQ - LO_CNT;

    map_ent_t          map_q [NUM_REQ];
    map_ent_t          new_ent;
    logic              hit;
    logic              refuse;
    logic [IDX_W-1:0]  idx;
    int unsigned       a_u;
    logic [1:0]        unused_pad;

    assign unused_pad = wdata_i[6:5];
    assign new_ent    = ent_from_bus(wdata_i);

    always_comb begin
        a_u = 32'(addr_i);
        hit = 1'b0;
        idx = '0;
        if (a_u >= LO_BASE && a_u < LO_BASE + LO_CNT) begin
            hit = 1'b1;
            idx = IDX_W'(a_u - LO_BASE);
        end else if (HI_CNT > 0 && a_u >= HI_BASE && a_u < HI_BASE + HI_CNT) begin
            hit = 1'b1;
            idx = IDX_W'(a_u - HI_BASE + LO_CNT);
        end
    end

    assign refuse = wr_i && hit && new_ent.live && (32'(new_ent.ch) >= NUM_CH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REQ; r++) map_q[r] <= '0;
            err_o   <= 1'b0;
            rdata_o <= '0;
        end else begin
            err_o <= refuse;
            if (wr_i && hit && !refuse) map_q[idx] <= new_ent;
            if (rd_i) rdata_o <= hit ? ent_to_bus(map_q[idx]) : 8'h00;
        end
    end

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_out
        assign map_o[r] = map_q[r];
    end

endmodule

// File: rtl/reqmap_level.sv
module reqmap_level
    import reqmap_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic [NUM_REQ-1:0]     req_q_i,
    input  map_ent_t [NUM_REQ-1:0] map_i,
    output logic [NUM_CH-1:0]      lvl_o
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic any_c;
        always_comb begin
            any_c = 1'b0;
            for (int r = 0; r < NUM_REQ; r++) begin
                if (map_i[r].live && (32'(map_i[r].ch) == c) && req_q_i[r])
                    any_c = 1'b1;
            end
        end
        assign lvl_o[c] = any_c;
    end

endmodule

// File: rtl/reqmap_edge.sv
module reqmap_edge #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] lvl_i,
    output logic [NUM_CH-1:0] lvl_q_o,
    output logic [NUM_CH-1:0] rise_o,
    output logic [NUM_CH-1:0] fall_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q_o <= '0;
            rise_o  <= '0;
            fall_o  <= '0;
        end else begin
            rise_o  <= lvl_i & ~lvl_q_o;
            fall_o  <= ~lvl_i & lvl_q_o;
            lvl_q_o <= lvl_i;
        end
    end

endmodule

// File: rtl/reqmap_top.sv
module reqmap_top
    import reqmap_pkg::*;
#(
    parameter int          NUM_REQ = 75,
    parameter int          NUM_CH  = 16,
    parameter int          ADDR_W  = 12,
    parameter int unsigned LO_BASE = 32'h040,
    parameter int unsigned HI_BASE = 32'h440
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic               cfg_wr_i,
    input  logic               cfg_rd_i,
    input  logic [ADDR_W-1:0]  cfg_addr_i,
    input  logic [7:0]         cfg_wdata_i,
    output logic [7:0]         cfg_rdata_o,
    output logic               cfg_err_o,
    output logic [NUM_CH-1:0]  chan_req_o,
    output logic [NUM_CH-1:0]  ras_set_o,
    output logic [NUM_CH-1:0]  ras_clr_o,
    output logic [NUM_CH-1:0]  eor_set_o,
    output logic [NUM_CH-1:0]  wake_o
);

    logic [NUM_REQ-1:0]     req_q;
    map_ent_t [NUM_REQ-1:0] map_w;
    logic [NUM_CH-1:0]      lvl_w;
    logic [NUM_CH-1:0]      rise_w;
    logic [NUM_CH-1:0]      fall_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_i;
    end

    reqmap_table #(
        .NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W),
        .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_i(cfg_wr_i), .rd_i(cfg_rd_i), .addr_i(cfg_addr_i),
        .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o), .err_o(cfg_err_o),
        .map_o(map_w)
    );

    reqmap_level #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_level (
        .req_q_i(req_q), .map_i(map_w), .lvl_o(lvl_w)
    );

    reqmap_edge #(.NUM_CH(NUM_CH)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl_w),
        .lvl_q_o(chan_req_o), .rise_o(rise_w), .fall_o(fall_w)
    );

    assign ras_set_o = rise_w;
    assign wake_o    = rise_w;
    assign eor_set_o = fall_w;
    assign ras_clr_o = fall_w;

endmodule

// File: rtl/reqmap_chk.sv
module reqmap_chk #(
    parameter int NUM_CH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_i,
    input logic [7:0]        cfg_rdata_o,
    input logic              cfg_err_o,
    input logic [NUM_CH-1:0] chan_req_o,
    input logic [NUM_CH-1:0] ras_set_o,
    input logic [NUM_CH-1:0] eor_set_o
);

    AST_RISE_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ras_set_o == (chan_req_o & ~$past(chan_req_o)));        // R6

    AST_FALL_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        eor_set_o == (~chan_req_o & $past(chan_req_o)));        // R7

    AST_NO_RISE_AND_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_set_o & eor_set_o) == '0);                          // R10

    AST_ERR_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> $past(cfg_wr_i));                          // R4

    AST_READ_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata_o[6:5] == 2'b00);                              // R2

endmodule

bind reqmap_top reqmap_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr_i),
    .cfg_rdata_o(cfg_rdata_o), .cfg_err_o(cfg_err_o),
    .chan_req_o(chan_req_o), .ras_set_o(ras_set_o), .eor_set_o(eor_set_o)
);

// File: tb/tb_reqmap_top.sv
module tb_reqmap_top;

    localparam int NRQ = 75;
    localparam int NCH = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NRQ-1:0]   req_i = '0;
    logic             cfg_wr_i = 1'b0;
    logic             cfg_rd_i = 1'b0;
    logic [11:0]      cfg_addr_i = '0;
    logic [7:0]       cfg_wdata_i = '0;
    logic [7:0]       cfg_rdata_o;
    logic             cfg_err_o;
    logic [NCH-1:0]   chan_req_o, ras_set_o, ras_clr_o, eor_set_o, wake_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    reqmap_top dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i),
        .cfg_wr_i(cfg_wr_i), .cfg_rd_i(cfg_rd_i), .cfg_addr_i(cfg_addr_i),
        .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o), .cfg_err_o(cfg_err_o),
        .chan_req_o(chan_req_o), .ras_set_o(ras_set_o), .ras_clr_o(ras_clr_o),
        .eor_set_o(eor_set_o), .wake_o(wake_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] addr_of(input int i);
        return (i < 64) ? 12'(12'h040 + i) : 12'(12'h440 + i - 64);
    endfunction

    function automatic logic [NCH-1:0] bit_of(input int c);
        return NCH'(1) << c;
    endfunction

    task automatic wr(input logic [11:0] a, input logic [7:0] d, output logic err);
        cfg_wr_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
        tick(1);
        cfg_wr_i = 1'b0;
        err = cfg_err_o;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        cfg_rd_i = 1'b1; cfg_addr_i = a;
        tick(1);
        cfg_rd_i = 1'b0;
        d = cfg_rdata_o;
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        logic       e;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        chk(chan_req_o == 0 && ras_set_o == 0 && eor_set_o == 0, "R1 outputs", {ras_set_o, chan_req_o}, 0);
        chk(cfg_err_o == 0, "R1 err", cfg_err_o, 0);
        chk(cfg_rdata_o == 0, "R1 rdata", cfg_rdata_o, 0);
        rd(addr_of(0), d);  chk(d == 8'h00, "R1 entry0", d, 0);
        rd(addr_of(74), d); chk(d == 8'h00, "R1 entry74", d, 0);

        // R2 R3 exhaustive write and readback, pad bits set on write
        for (int i = 0; i < NRQ; i++) begin
            wr(addr_of(i), 8'hE0 | 8'(i % NCH), e);
            chk(e == 1'b0, "R2 no err", e, 0);
        end
        for (int i = 0; i < NRQ; i++) begin
            rd(addr_of(i), d);
            chk(d == (8'h80 | 8'(i % NCH)), "R2 R3 readback", d, 8'h80 | 8'(i % NCH));
        end

        // R3 addresses outside both windows
        rd(12'h44B, d); chk(d == 8'h00, "R3 past hi window", d, 0);
        rd(12'h03F, d); chk(d == 8'h00, "R3 below lo window", d, 0);
        wr(12'h44B, 8'h85, e); chk(e == 1'b0, "R3 stray write err", e, 0);
        wr(12'h080, 8'h83, e); chk(e == 1'b0, "R3 stray write err lo", e, 0);
        rd(addr_of(74), d); chk(d == 8'h8A, "R3 entry74 intact", d, 8'h8A);
        rd(addr_of(0), d);  chk(d == 8'h80, "R3 entry0 intact", d, 8'h80);

        // R4 channel bound
        wr(addr_of(5), 8'h8F, e); chk(e == 1'b0, "R4 ch15 accepted", e, 0);
        rd(addr_of(5), d); chk(d == 8'h8F, "R4 ch15 stored", d, 8'h8F);
        wr(addr_of(5), 8'h90, e); chk(e == 1'b1, "R4 ch16 refused", e, 1);
        tick(1); chk(cfg_err_o == 1'b0, "R4 err one cycle", cfg_err_o, 0);
        rd(addr_of(5), d); chk(d == 8'h8F, "R4 entry unchanged", d, 8'h8F);
        wr(addr_of(5), 8'h94, e); chk(e == 1'b1, "R4 ch20 refused", e, 1);
        wr(addr_of(5), 8'h14, e); chk(e == 1'b0, "R4 not live stored", e, 0);
        rd(addr_of(5), d); chk(d == 8'h14, "R4 not live readback", d, 8'h14);
        wr(addr_of(5), 8'h85, e);

        // R6 R7 R9 R10 every request line routes to its own channel
        for (int r = 0; r < NRQ; r++) begin
            logic [NCH-1:0] x;
            x = bit_of(r % NCH);
            req_i[r] = 1'b1;
            tick(2);
            chk(ras_set_o == x && wake_o == x, "R6 rise pulse", ras_set_o, x);
            chk(chan_req_o == x, "R9 level high", chan_req_o, x);
            chk(eor_set_o == 0, "R10 no fall on rise", eor_set_o, 0);
            tick(1);
            chk(ras_set_o == 0 && chan_req_o == x, "R6 single pulse", ras_set_o, 0);
            req_i[r] = 1'b0;
            tick(2);
            chk(eor_set_o == x && ras_clr_o == x, "R7 fall pulse", eor_set_o, x);
            chk(chan_req_o == 0 && ras_set_o == 0, "R9 level low", chan_req_o, 0);
            tick(1);
            chk(eor_set_o == 0, "R7 single pulse", eor_set_o, 0);
        end

        // R5 entry not live
        wr(addr_of(3), 8'h03, e);
        req_i[3] = 1'b1;
        tick(2);
        chk(chan_req_o == 0 && ras_set_o == 0 && wake_o == 0, "R5 rise ignored", chan_req_o, 0);
        tick(2);
        chk(chan_req_o == 0, "R5 still idle", chan_req_o, 0);
        req_i[3] = 1'b0;
        tick(2);
        chk(eor_set_o == 0 && ras_clr_o == 0, "R5 fall ignored", eor_set_o, 0);
        wr(addr_of(3), 8'h83, e);

        // R8 lines 1 and 17 share channel 1
        req_i[1] = 1'b1; tick(2);
        chk(ras_set_o == 16'h0002, "R8 first rise", ras_set_o, 16'h0002);
        tick(1);
        req_i[17] = 1'b1; tick(2);
        chk(ras_set_o == 0 && chan_req_o == 16'h0002, "R8 second rise silent", ras_set_o, 0);
        req_i[1] = 1'b0; tick(2);
        chk(eor_set_o == 0 && chan_req_o == 16'h0002, "R8 partial drop silent", eor_set_o, 0);
        req_i[17] = 1'b0; tick(2);
        chk(eor_set_o == 16'h0002, "R8 last drop", eor_set_o, 16'h0002);
        tick(1);

        // R10 two channels at once
        req_i[2] = 1'b1; req_i[5] = 1'b1; tick(2);
        chk(ras_set_o == 16'h0024, "R10 joint rise", ras_set_o, 16'h0024);
        tick(1);
        req_i[2] = 1'b0; req_i[5] = 1'b0; tick(2);
        chk(eor_set_o == 16'h0024, "R10 joint fall", eor_set_o, 16'h0024);
        tick(2);

        finish_run();
    end

endmodule